// File: doc/BRIEF.md
# Banked UART Register Interface

This block is the host-visible register file of a PC-compatible serial port. A byte-wide host bus with a three-bit offset reaches eight locations. The value held in the line-control register decides what several of those locations mean. With its top bit clear, the normal bank is active. With its top bit set, offsets 0 and 1 reach the two bytes of the baud divisor. When it holds the one key value 0xBF, an extra feature register appears at offset 2 and the scratch location is hidden.

The serial shifters, the FIFO storage and the baud generator sit outside this block. They are connected through plain signals. The block receives status flags and the received byte, and it drives the 16-bit divisor, the line-control byte, the FIFO mode bits, the flow-control enables and one-cycle strobes for data push, data pop and FIFO clear. Host reads are combinational. Register updates and strobes take effect on the clock edge that samples the access.

Top module: `uart_regbank`

## Requirements
- R1: After reset, with no received data and an empty, idle transmitter, offsets 1..7 read 0x00, 0x01, 0x00, 0x00, 0x60, 0x00, 0x00, and the divisor output is 0x0000.
- R2: With line-control bit 7 clear, a write to offset 0 loads tx_byte and pulses tx_push high for exactly the one cycle after the write edge. A read of offset 0 returns rx_byte and pulses rx_pop in the same way.
- R3: With line-control bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. These accesses raise no push or pop and leave the interrupt-enable value unchanged.
- R4: While line control equals 0xBF, offset 2 reads and writes the feature register and leaves the FIFO mode unchanged. Feature bit 7 drives auto_cts and feature bit 6 drives auto_rts.
- R5: While line control equals 0xBF, offset 7 reads 0x00 and ignores writes. The earlier scratch value reads back once line control changes.
- R6: Line status reads live as bit 0 = rx_ready, bit 5 = thr_empty, bit 6 = tx_idle, with every other bit 0.
- R7: A FIFO-control write sets fifo_en from bit 0 and sets fifo_deep from bit 5 ANDed with bit 0. Interrupt-identification bits 7:6 read as two copies of fifo_en, and bit 5 reads as fifo_deep.
- R8: FIFO-control bit 1 pulses rx_fifo_clr and bit 2 pulses tx_fifo_clr, each for exactly one cycle after the write edge.
- R9: Modem control keeps only bit 0 (dtr), bit 1 (rts) and bit 5 (auto_flow). Those bits read back and drive their outputs, and every other bit reads 0.
- R10: Interrupt-enable keeps bits 3:0 only. The interrupt-identification low nibble reads 0x4 when enable bit 0 and rx_ready are both set. Otherwise it reads 0x2 when enable bit 1 and thr_empty are both set, and otherwise 0x1. The irq output is the inverse of that nibble's bit 0.
- R11: Writes to offsets 5 and 6 have no effect, offset 6 reads 0x00, and line_ctrl always equals the line-control value.
- R12: In the normal bank, offset 7 stores and returns any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_byte | input | 8 | Received byte at the head of the receiver |
| rx_ready | input | 1 | Received data available |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_idle | input | 1 | Transmitter completely empty |
| tx_byte | output | 8 | Byte last written for transmission |
| tx_push | output | 1 | One-cycle transmit push strobe |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| fifo_en | output | 1 | FIFOs enabled |
| fifo_deep | output | 1 | 64-byte FIFO mode |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line-control value (frame format) |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| auto_flow | output | 1 | Modem-control auto-flow enable |
| auto_cts | output | 1 | Automatic CTS flow control enable |
| auto_rts | output | 1 | Automatic RTS flow control enable |
| irq | output | 1 | Interrupt pending |

## Verification
The hardest state to reach is the key-value bank. In that bank, offset 2 and offset 7 change meaning and the divisor bank is active at the same time, so a write there must not touch the FIFO mode or the scratch byte. The stimulus first loads a known scratch byte and enables the FIFOs. It then writes 0xBF to line control, writes the feature register and the hidden scratch location, and returns line control to 0x03. Finally it reads back that the scratch byte and the FIFO bits survived, which exposes any leak between the overlaid locations.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int DW        = 8;
    localparam int AW        = 3;
    localparam int DIV_W     = 16;
    localparam int DIV_LANES = DIV_W / DW;
    localparam int IEN_W     = 4;

    localparam logic [DW-1:0] ENH_KEY = 8'hBF;

    localparam int LC_DLAB   = 7;
    localparam int FC_EN     = 0;
    localparam int FC_RXCLR  = 1;
    localparam int FC_TXCLR  = 2;
    localparam int FC_DEEP   = 5;
    localparam int MC_DTR    = 0;
    localparam int MC_RTS    = 1;
    localparam int MC_AFC    = 5;
    localparam int LS_RDY    = 0;
    localparam int LS_THRE   = 5;
    localparam int LS_IDLE   = 6;
    localparam int EF_CTS    = 7;
    localparam int EF_RTS    = 6;

    typedef enum logic [AW-1:0] {
        OFF_DATA  = 3'd0,
        OFF_IEN   = 3'd1,
        OFF_CTL2  = 3'd2,
        OFF_LINE  = 3'd3,
        OFF_MODEM = 3'd4,
        OFF_LSTAT = 3'd5,
        OFF_MSTAT = 3'd6,
        OFF_SCR   = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic [DIV_LANES-1:0] div;
        logic data;
        logic ien;
        logic ident;
        logic efr;
        logic line;
        logic modem;
        logic lstat;
        logic mstat;
        logic scratch;
        logic hidden;
    } sel_t;

    typedef struct packed {
        logic [IEN_W-1:0]               ien;
        logic [DW-1:0]                  line;
        logic [DW-1:0]                  scratch;
        logic [DW-1:0]                  efr;
        logic [DW-1:0]                  tx_byte;
        logic                           dtr;
        logic                           rts;
        logic                           afc;
        logic                           fifo_en;
        logic                           fifo_deep;
        logic [DIV_LANES-1:0][DW-1:0]   div;
        logic                           tx_push;
        logic                           rx_pop;
        logic                           rx_clr;
        logic                           tx_clr;
    } st_t;

endpackage

// File: rtl/uart_rb_bank.sv
module uart_rb_bank
    import uart_rb_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] line_q,
    output sel_t          sel
);
    logic dlab;
    logic enh;

    assign dlab = line_q[LC_DLAB];
    assign enh  = (line_q == ENH_KEY);

    always_comb begin
        sel = '0;
        for (int i = 0; i < DIV_LANES; i++) begin
            sel.div[i] = dlab && (addr == AW'(i));
        end
        sel.data    = !dlab && (addr == OFF_DATA);
        sel.ien     = !dlab && (addr == OFF_IEN);
        sel.ident   = !enh  && (addr == OFF_CTL2);
        sel.efr     =  enh  && (addr == OFF_CTL2);
        sel.line    = (addr == OFF_LINE);
        sel.modem   = (addr == OFF_MODEM);
        sel.lstat   = (addr == OFF_LSTAT);
        sel.mstat   = (addr == OFF_MSTAT);
        sel.scratch = !enh  && (addr == OFF_SCR);
        sel.hidden  =  enh  && (addr == OFF_SCR);
    end

endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
    import uart_rb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  sel_t          sel,
    output st_t           st_q
);
    st_t st_d;

    always_comb begin
        st_d         = st_q;
        st_d.tx_push = 1'b0;
        st_d.rx_pop  = 1'b0;
        st_d.rx_clr  = 1'b0;
        st_d.tx_clr  = 1'b0;

        if (wr) begin
            if (sel.data) begin
                st_d.tx_byte = wdata;
                st_d.tx_push = 1'b1;
            end
            if (sel.ien) begin
                st_d.ien = wdata[IEN_W-1:0];
            end
            for (int i = 0; i < DIV_LANES; i++) begin
                if (sel.div[i]) begin
                    st_d.div[i] = wdata;
                end
            end
            if (sel.ident) begin
                st_d.fifo_en   = wdata[FC_EN];
                st_d.fifo_deep = wdata[FC_EN] && wdata[FC_DEEP];
                st_d.rx_clr    = wdata[FC_RXCLR];
                st_d.tx_clr    = wdata[FC_TXCLR];
            end
            if (sel.efr) begin
                st_d.efr = wdata;
            end
            if (sel.line) begin
                st_d.line = wdata;
            end
            if (sel.modem) begin
                st_d.dtr = wdata[MC_DTR];
                st_d.rts = wdata[MC_RTS];
                st_d.afc = wdata[MC_AFC];
            end
            if (sel.scratch) begin
                st_d.scratch = wdata;
            end
        end

        if (rd && sel.data) begin
            st_d.rx_pop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    efr_keeps_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel.efr) |=> $stable({st_q.fifo_en, st_q.fifo_deep}));

    // R5
    hidden_scr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel.hidden) |=> $stable(st_q.scratch));

    // R8
    rxclr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_clr |-> $past(wr && sel.ident && wdata[FC_RXCLR]));

    // R2
    pop_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_pop |-> $past(rd && sel.data));

endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
    import uart_rb_pkg::*;
(
    input  sel_t          sel,
    input  st_t           st,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_ready,
    input  logic          thr_empty,
    input  logic          tx_idle,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    logic [3:0]    id_low;
    logic [DW-1:0] ident;
    logic [DW-1:0] lstat;
    logic [DW-1:0] modem;

    always_comb begin
        if (st.ien[0] && rx_ready) begin
            id_low = 4'h4;
        end else if (st.ien[1] && thr_empty) begin
            id_low = 4'h2;
        end else begin
            id_low = 4'h1;
        end
        ident      = '0;
        ident[3:0] = id_low;
        ident[7]   = st.fifo_en;
        ident[6]   = st.fifo_en;
        ident[5]   = st.fifo_deep;

        lstat          = '0;
        lstat[LS_RDY]  = rx_ready;
        lstat[LS_THRE] = thr_empty;
        lstat[LS_IDLE] = tx_idle;

        modem         = '0;
        modem[MC_DTR] = st.dtr;
        modem[MC_RTS] = st.rts;
        modem[MC_AFC] = st.afc;
    end

    assign irq = !id_low[0];

    always_comb begin
        rdata = '0;
        if (sel.data)    rdata = rx_byte;
        if (sel.ien)     rdata = {{(DW-IEN_W){1'b0}}, st.ien};
        for (int i = 0; i < DIV_LANES; i++) begin
            if (sel.div[i]) rdata = st.div[i];
        end
        if (sel.ident)   rdata = ident;
        if (sel.efr)     rdata = st.efr;
        if (sel.line)    rdata = st.line;
        if (sel.modem)   rdata = modem;
        if (sel.lstat)   rdata = lstat;
        if (sel.scratch) rdata = st.scratch;
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    rx_byte,
    input  logic             rx_ready,
    input  logic             thr_empty,
    input  logic             tx_idle,
    output logic [DW-1:0]    tx_byte,
    output logic             tx_push,
    output logic             rx_pop,
    output logic             rx_fifo_clr,
    output logic             tx_fifo_clr,
    output logic             fifo_en,
    output logic             fifo_deep,
    output logic [DIV_W-1:0] divisor,
    output logic [DW-1:0]    line_ctrl,
    output logic             dtr,
    output logic             rts,
    output logic             auto_flow,
    output logic             auto_cts,
    output logic             auto_rts,
    output logic             irq
);
    sel_t sel;
    st_t  st_q;

    uart_rb_bank i_bank (
        .addr   (bus_addr),
        .line_q (st_q.line),
        .sel    (sel)
    );

    uart_rb_regs i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .sel   (sel),
        .st_q  (st_q)
    );

    uart_rb_rdmux i_rdmux (
        .sel       (sel),
        .st        (st_q),
        .rx_byte   (rx_byte),
        .rx_ready  (rx_ready),
        .thr_empty (thr_empty),
        .tx_idle   (tx_idle),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

    assign tx_byte     = st_q.tx_byte;
    assign tx_push     = st_q.tx_push;
    assign rx_pop      = st_q.rx_pop;
    assign rx_fifo_clr = st_q.rx_clr;
    assign tx_fifo_clr = st_q.tx_clr;
    assign fifo_en     = st_q.fifo_en;
    assign fifo_deep   = st_q.fifo_deep;
    assign divisor     = st_q.div;
    assign line_ctrl   = st_q.line;
    assign dtr         = st_q.dtr;
    assign rts         = st_q.rts;
    assign auto_flow   = st_q.afc;
    assign auto_cts    = st_q.efr[EF_CTS];
    assign auto_rts    = st_q.efr[EF_RTS];

    // R3
    div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !line_ctrl[LC_DLAB]) |=> $stable(divisor));

    // R7
    ident_fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CTL2 && line_ctrl != ENH_KEY) |-> (bus_rdata[7:6] == {2{fifo_en}}));

    // R2
    push_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(bus_wr && bus_addr == OFF_DATA && !line_ctrl[LC_DLAB]));

    // R5
    hidden_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_SCR && line_ctrl == ENH_KEY) |-> (bus_rdata == '0));

endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready = 1'b0;
    logic        thr_empty = 1'b1;
    logic        tx_idle = 1'b1;
    logic [7:0]  tx_byte;
    logic        tx_push, rx_pop, rx_fifo_clr, tx_fifo_clr;
    logic        fifo_en, fifo_deep;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl;
    logic        dtr, rts, auto_flow, auto_cts, auto_rts, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] rd_val;
    logic cap_push, cap_pop, cap_rxclr, cap_txclr;

    always #2 clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .thr_empty(thr_empty),
        .tx_idle(tx_idle), .tx_byte(tx_byte), .tx_push(tx_push),
        .rx_pop(rx_pop), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
        .fifo_en(fifo_en), .fifo_deep(fifo_deep), .divisor(divisor),
        .line_ctrl(line_ctrl), .dtr(dtr), .rts(rts), .auto_flow(auto_flow),
        .auto_cts(auto_cts), .auto_rts(auto_rts), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        cap_push = tx_push; cap_rxclr = rx_fifo_clr; cap_txclr = tx_fifo_clr;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        cap_pop = rx_pop;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd_reg(3'd1); check("R1 ien", rd_val, 8'h00);
        rd_reg(3'd2); check("R1 ident", rd_val, 8'h01);
        rd_reg(3'd3); check("R1 line", rd_val, 8'h00);
        rd_reg(3'd4); check("R1 modem", rd_val, 8'h00);
        rd_reg(3'd5); check("R1 lstat", rd_val, 8'h60);
        rd_reg(3'd6); check("R1 mstat", rd_val, 8'h00);
        rd_reg(3'd7); check("R1 scratch", rd_val, 8'h00);
        check("R1 divisor", divisor, 16'h0000);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_data;
        wr_reg(3'd0, 8'hA5);
        check("R2 push pulse", cap_push, 1'b1);
        check("R2 tx_byte", tx_byte, 8'hA5);
        @(negedge clk); check("R2 push one cycle", tx_push, 1'b0);
        rx_byte = 8'h3C;
        rd_reg(3'd0);
        check("R2 rx read", rd_val, 8'h3C);
        check("R2 pop pulse", cap_pop, 1'b1);
        @(negedge clk); check("R2 pop one cycle", rx_pop, 1'b0);
    endtask

    task automatic t_divisor;
        wr_reg(3'd1, 8'hF3);
        rd_reg(3'd1); check("R10 ien low bits", rd_val, 8'h03);
        wr_reg(3'd3, 8'h80);
        wr_reg(3'd0, 8'h34); check("R3 no push", cap_push, 1'b0);
        wr_reg(3'd1, 8'h12);
        check("R3 divisor", divisor, 16'h1234);
        rd_reg(3'd1); check("R3 high lane", rd_val, 8'h12);
        rd_reg(3'd0); check("R3 low lane", rd_val, 8'h34);
        check("R3 no pop", cap_pop, 1'b0);
        wr_reg(3'd3, 8'h03);
        rd_reg(3'd1); check("R3 ien kept", rd_val, 8'h03);
        check("R11 line_ctrl out", line_ctrl, 8'h03);
        wr_reg(3'd1, 8'h00);
    endtask

    task automatic t_enhanced;
        wr_reg(3'd7, 8'h77);
        wr_reg(3'd2, 8'h01);
        check("R7 fifo_en", fifo_en, 1'b1);
        wr_reg(3'd3, 8'hBF);
        wr_reg(3'd2, 8'hC0);
        check("R4 fifo kept", fifo_en, 1'b1);
        check("R4 no clear strobe", cap_rxclr | cap_txclr, 1'b0);
        check("R4 auto_cts", auto_cts, 1'b1);
        check("R4 auto_rts", auto_rts, 1'b1);
        rd_reg(3'd2); check("R4 efr read", rd_val, 8'hC0);
        rd_reg(3'd7); check("R5 hidden read", rd_val, 8'h00);
        wr_reg(3'd7, 8'h11);
        wr_reg(3'd3, 8'h03);
        rd_reg(3'd7); check("R5 scratch survives", rd_val, 8'h77);
        rd_reg(3'd2); check("R4 ident back", rd_val, 8'hC1);
    endtask

    task automatic t_lstat;
        rx_ready = 1; thr_empty = 0; tx_idle = 0;
        rd_reg(3'd5); check("R6 ready only", rd_val, 8'h01);
        rx_ready = 0; thr_empty = 1;
        rd_reg(3'd5); check("R6 thre only", rd_val, 8'h20);
        thr_empty = 0; tx_idle = 1;
        rd_reg(3'd5); check("R6 idle only", rd_val, 8'h40);
        rx_ready = 1; thr_empty = 1;
        rd_reg(3'd5); check("R6 all", rd_val, 8'h61);
        rx_ready = 0;
    endtask

    task automatic t_fifo;
        wr_reg(3'd2, 8'h27);
        check("R8 rx clr", cap_rxclr, 1'b1);
        check("R8 tx clr", cap_txclr, 1'b1);
        @(negedge clk);
        check("R8 clr one cycle", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
        rd_reg(3'd2); check("R7 deep ident", rd_val, 8'hE1);
        check("R7 fifo_deep", fifo_deep, 1'b1);
        wr_reg(3'd2, 8'h01);
        rd_reg(3'd2); check("R7 shallow ident", rd_val, 8'hC1);
        wr_reg(3'd2, 8'h20);
        rd_reg(3'd2); check("R7 disabled ident", rd_val, 8'h01);
        check("R7 deep needs enable", fifo_deep, 1'b0);
        wr_reg(3'd2, 8'h02);
        check("R8 rx clr only", {cap_rxclr, cap_txclr}, 2'b10);
    endtask

    task automatic t_modem;
        wr_reg(3'd4, 8'hFF);
        rd_reg(3'd4); check("R9 modem mask", rd_val, 8'h23);
        check("R9 outputs", {dtr, rts, auto_flow}, 3'b111);
        wr_reg(3'd4, 8'h20);
        rd_reg(3'd4); check("R9 afc only", rd_val, 8'h20);
        check("R9 dtr low", dtr, 1'b0);
    endtask

    task automatic t_ident;
        wr_reg(3'd1, 8'h03);
        rd_reg(3'd2); check("R10 thre id", rd_val, 8'h02);
        check("R10 irq on", irq, 1'b1);
        rx_ready = 1;
        rd_reg(3'd2); check("R10 rx priority", rd_val, 8'h04);
        wr_reg(3'd1, 8'h00);
        rd_reg(3'd2); check("R10 none", rd_val, 8'h01);
        check("R10 irq off", irq, 1'b0);
        rx_ready = 0;
    endtask

    task automatic t_ignored;
        wr_reg(3'd5, 8'hFF);
        wr_reg(3'd6, 8'hFF);
        rd_reg(3'd5); check("R11 lstat unwritable", rd_val, 8'h60);
        rd_reg(3'd6); check("R11 mstat zero", rd_val, 8'h00);
        wr_reg(3'd3, 8'h1B);
        check("R11 line_ctrl", line_ctrl, 8'h1B);
        wr_reg(3'd3, 8'h03);
    endtask

    task automatic t_scratch;
        wr_reg(3'd7, 8'hA5);
        rd_reg(3'd7); check("R12 scratch A5", rd_val, 8'hA5);
        wr_reg(3'd7, 8'h5A);
        rd_reg(3'd7); check("R12 scratch 5A", rd_val, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data();
        t_divisor();
        t_enhanced();
        t_lstat();
        t_fifo();
        t_modem();
        t_ident();
        t_ignored();
        t_scratch();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule